// File: doc/BRIEF.md
# Two-Bit Adaptive Delta Modulation Encoder

This block encodes a stream of signed fixed-point PCM samples into a 2-bit code per sample. It keeps a running prediction of the input and a step size. For every sample strobe it takes the difference between the new sample and the current prediction. It emits a direction bit, which is the sign of that difference, and a magnitude bit. The magnitude bit tells a matching decoder whether the step grew or shrank. The decoder can then rebuild the same prediction from the codes alone.

The step size adapts on every sample. Three factors drive it:
- a memory factor, set by whether the direction bit repeated;
- a look-ahead factor, set by comparing the error magnitude against a threshold that sits midway between the two candidate steps;
- an extra boost, applied when the magnitude bit is low on two consecutive samples.

Together these give six distinct step multipliers. All multiplier constants are unsigned Q4.12 inputs, so one instance can run with any constant set. The step is clamped between two programmable bounds. The prediction saturates at the sample range.

Top module: `adm2_encoder`

## Requirements
- R1: A code and a one-cycle `code_valid` pulse appear on the clock edge after the edge that sampled `smp_valid` high. Without a strobe, `code_valid` is low and the prediction and step do not change.
- R2: `code_sign` is 1 (direction +1) when x − y ≥ 0, where y is the prediction before this sample. Otherwise `code_sign` is 0 (direction −1).
- R3: The intermediate step D1 is q(K, Δprev). K is `k_alpha` when the direction bit equals the previous direction bit, and `k_alpha_inv` when it differs.
- R4: `code_mag` is 1 (+1) when |x − y| ≥ q(`k_thresh`, D1), and 0 (−1) otherwise.
- R5: D2 = q(`k_beta`, D1) when `code_mag` is 1, and q(`k_beta_inv`, D1) otherwise. When both this magnitude bit and the previous one are 0, D3 = q(`k_gamma`, D2); otherwise D3 = D2.
- R6: The new step is D3 clamped to [`step_min`, `step_max`].
- R7: The new prediction is y + Δ when `code_sign` is 1, and y − Δ otherwise, where Δ is the new step. It saturates to the signed DW-bit range and does not wrap.
- R8: Reset (synchronous, active high) sets y = 0, the step to `init_step`, both previous bits to +1, and `code_valid` to 0.
- R9: q(K, v) = floor((K·v + 2048) / 4096), saturated to 2^SW − 1. K is an unsigned 16-bit Q4.12 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_step | input | SW | Step loaded at reset |
| step_min | input | SW | Lower step bound |
| step_max | input | SW | Upper step bound |
| k_alpha | input | 16 | Memory factor for a repeated direction, Q4.12 |
| k_alpha_inv | input | 16 | Memory factor for a changed direction, Q4.12 |
| k_beta | input | 16 | Growth factor, Q4.12 |
| k_beta_inv | input | 16 | Shrink factor, Q4.12 |
| k_gamma | input | 16 | Boost after two low magnitude bits, Q4.12 |
| k_thresh | input | 16 | Threshold factor (β + 1/β)/2, Q4.12 |
| smp_valid | input | 1 | Sample strobe |
| smp_in | input | DW | Signed input sample |
| code_valid | output | 1 | Code strobe, one clock after `smp_valid` |
| code_sign | output | 1 | Direction bit (1 = +1) |
| code_mag | output | 1 | Magnitude bit (1 = +1) |

## Verification
The bench builds the encoder with DW = 10 and SW = 10. With these widths a sweep covers the whole input range in a few hundred samples. Steps near 1023 push the intermediate products into saturation, and full-scale inputs drive the prediction into both rails within a few dozen samples. Two constant sets run against the same bench model: a moderate one (α = 1.1, β = 1.9, γ = 1.5) and an aggressive one (α = 1.5, β = 2.5, γ = 2.0). The tight clamp bounds, mid-run resets and idle gaps are each reached directly.

// File: rtl/adm2_pkg.sv
package adm2_pkg;
  localparam int KW   = 16;   // width of a Q4.12 constant
  localparam int FRAC = 12;   // fractional bits of a constant

  typedef struct packed {
    logic sgn;  // 1 = direction +1
    logic mag;  // 1 = step grows
  } adm2_code_t;
endpackage

// File: rtl/adm2_qmul.sv
// Rounded, saturating product of an unsigned fixed-point constant and a step.
module adm2_qmul #(
  parameter int VW   = 16,
  parameter int KW   = adm2_pkg::KW,
  parameter int FRAC = adm2_pkg::FRAC
) (
  input  logic [KW-1:0] k,
  input  logic [VW-1:0] v,
  output logic [VW-1:0] p
);
  localparam int PW = KW + VW + 1;
  localparam logic [PW-1:0] HALF = PW'(1) << (FRAC - 1);

  logic [PW-1:0] full;
  logic [PW-1:0] shr;
  logic          ovf;

  always_comb begin
    full = PW'(k) * PW'(v) + HALF;
    shr  = full >> FRAC;
    ovf  = |shr[PW-1:VW];
    p    = ovf ? {VW{1'b1}} : shr[VW-1:0];
  end
endmodule

// File: rtl/adm2_step_adapt.sv
// Step adaptation: memory factor, look-ahead comparison, boost, clamp.
module adm2_step_adapt #(
  parameter int SW = 16,
  parameter int CW = 17
) (
  input  logic [SW-1:0]              step_prev,
  input  logic [CW-1:0]              err_abs,
  input  logic                       same_dir,
  input  logic                       mag_prev,
  input  logic [adm2_pkg::KW-1:0]    k_alpha,
  input  logic [adm2_pkg::KW-1:0]    k_alpha_inv,
  input  logic [adm2_pkg::KW-1:0]    k_beta,
  input  logic [adm2_pkg::KW-1:0]    k_beta_inv,
  input  logic [adm2_pkg::KW-1:0]    k_gamma,
  input  logic [adm2_pkg::KW-1:0]    k_thresh,
  input  logic [SW-1:0]              step_min,
  input  logic [SW-1:0]              step_max,
  output logic                       mag_bit,
  output logic [SW-1:0]              step_next
);
  logic [adm2_pkg::KW-1:0] k_mem, k_look;
  logic [SW-1:0] d1, thr, d2, d2_boost, d3;

  assign k_mem = same_dir ? k_alpha : k_alpha_inv;

  adm2_qmul #(.VW(SW)) u_mem   (.k(k_mem),    .v(step_prev), .p(d1));
  adm2_qmul #(.VW(SW)) u_thr   (.k(k_thresh), .v(d1),        .p(thr));

  assign mag_bit = err_abs >= CW'(thr);
  assign k_look  = mag_bit ? k_beta : k_beta_inv;

  adm2_qmul #(.VW(SW)) u_look  (.k(k_look),   .v(d1),        .p(d2));
  adm2_qmul #(.VW(SW)) u_boost (.k(k_gamma),  .v(d2),        .p(d2_boost));

  assign d3 = (!mag_bit && !mag_prev) ? d2_boost : d2;

  always_comb begin
    if (d3 < step_min)      step_next = step_min;
    else if (d3 > step_max) step_next = step_max;
    else                    step_next = d3;
  end
endmodule

// File: rtl/adm2_encoder.sv
module adm2_encoder #(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SW-1:0]                 init_step,
  input  logic [SW-1:0]                 step_min,
  input  logic [SW-1:0]                 step_max,
  input  logic [adm2_pkg::KW-1:0]       k_alpha,
  input  logic [adm2_pkg::KW-1:0]       k_alpha_inv,
  input  logic [adm2_pkg::KW-1:0]       k_beta,
  input  logic [adm2_pkg::KW-1:0]       k_beta_inv,
  input  logic [adm2_pkg::KW-1:0]       k_gamma,
  input  logic [adm2_pkg::KW-1:0]       k_thresh,
  input  logic                          smp_valid,
  input  logic signed [DW-1:0]          smp_in,
  output logic                          code_valid,
  output logic                          code_sign,
  output logic                          code_mag
);
  localparam int EW = DW + 1;
  localparam int CW = (EW > SW) ? EW : SW;
  localparam int YW = ((DW > SW) ? DW : SW) + 2;
  localparam logic signed [YW-1:0] YMAX = {{(YW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [YW-1:0] YMIN = {{(YW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] pred_q;
  logic [SW-1:0]        step_q;
  logic                 dir_prev_q, mag_prev_q;
  adm2_pkg::adm2_code_t code_q;
  logic                 valid_q;

  logic signed [EW-1:0] err;
  logic [EW-1:0]        err_abs;
  logic                 dir_now, mag_now;
  logic [SW-1:0]        step_next;
  logic signed [YW-1:0] pred_ext, step_ext, pred_sum;
  logic signed [DW-1:0] pred_next;

  always_comb begin
    err     = EW'(smp_in) - EW'(pred_q);
    dir_now = ~err[EW-1];
    err_abs = err[EW-1] ? EW'(-err) : EW'(err);
  end

  adm2_step_adapt #(.SW(SW), .CW(CW)) u_adapt (
    .step_prev   (step_q),
    .err_abs     (CW'(err_abs)),
    .same_dir    (dir_now == dir_prev_q),
    .mag_prev    (mag_prev_q),
    .k_alpha     (k_alpha),
    .k_alpha_inv (k_alpha_inv),
    .k_beta      (k_beta),
    .k_beta_inv  (k_beta_inv),
    .k_gamma     (k_gamma),
    .k_thresh    (k_thresh),
    .step_min    (step_min),
    .step_max    (step_max),
    .mag_bit     (mag_now),
    .step_next   (step_next)
  );

  always_comb begin
    pred_ext = YW'(pred_q);
    step_ext = YW'($signed({1'b0, step_next}));
    pred_sum = dir_now ? (pred_ext + step_ext) : (pred_ext - step_ext);
    if (pred_sum > YMAX)      pred_next = YMAX[DW-1:0];
    else if (pred_sum < YMIN) pred_next = YMIN[DW-1:0];
    else                      pred_next = pred_sum[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_q     <= '0;
      step_q     <= init_step;
      dir_prev_q <= 1'b1;
      mag_prev_q <= 1'b1;
      code_q     <= '0;
      valid_q    <= 1'b0;
    end else begin
      valid_q <= smp_valid;
      if (smp_valid) begin
        pred_q     <= pred_next;
        step_q     <= step_next;
        dir_prev_q <= dir_now;
        mag_prev_q <= mag_now;
        code_q     <= '{sgn: dir_now, mag: mag_now};
      end
    end
  end

  assign code_valid = valid_q;
  assign code_sign  = code_q.sgn;
  assign code_mag   = code_q.mag;
endmodule

// File: rtl/adm2_chk.sv
module adm2_chk #(
  parameter int DW = 16,
  parameter int SW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic signed [DW-1:0] smp_in,
  input logic                 code_valid,
  input logic                 code_sign,
  input logic signed [DW-1:0] pred_q,
  input logic [SW-1:0]        step_q,
  input logic [SW-1:0]        step_min,
  input logic [SW-1:0]        step_max
);
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> code_valid); // R1
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !code_valid); // R1
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> ($stable(pred_q) && $stable(step_q))); // R1
  AST_SIGN_FOLLOWS_ERROR: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> (code_sign == ($past(smp_in) >= $past(pred_q)))); // R2
  AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    (code_valid && $past(step_min) <= $past(step_max)) |->
      (step_q >= $past(step_min) && step_q <= $past(step_max))); // R6
  AST_PRED_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    code_valid |-> (code_sign ? (pred_q >= $past(pred_q)) : (pred_q <= $past(pred_q)))); // R7
endmodule

bind adm2_encoder adm2_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_in),
  .code_valid(code_valid), .code_sign(code_sign), .pred_q(pred_q),
  .step_q(step_q), .step_min(step_min), .step_max(step_max)
);

// File: tb/sim_adm2_encoder.sv
`timescale 1ns/1ps
module sim_adm2_encoder;
  localparam int DW = 10;
  localparam int SW = 10;
  localparam int SMAX = (1 << SW) - 1;
  localparam int YMAX = (1 << (DW-1)) - 1;
  localparam int YMIN = -(1 << (DW-1));

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] init_step, step_min, step_max;
  logic [15:0] k_alpha, k_alpha_inv, k_beta, k_beta_inv, k_gamma, k_thresh;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_in = '0;
  logic code_valid, code_sign, code_mag;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model of the encoder state
  int m_y, m_step;
  bit m_dir, m_mag;

  always #4 clk = ~clk;

  adm2_encoder #(.DW(DW), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .init_step(init_step), .step_min(step_min),
    .step_max(step_max), .k_alpha(k_alpha), .k_alpha_inv(k_alpha_inv),
    .k_beta(k_beta), .k_beta_inv(k_beta_inv), .k_gamma(k_gamma),
    .k_thresh(k_thresh), .smp_valid(smp_valid), .smp_in(smp_in),
    .code_valid(code_valid), .code_sign(code_sign), .code_mag(code_mag)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // R9: rounded, saturating Q4.12 product
  function automatic int q(input int k, input int v);
    int r;
    r = (k * v + 2048) >>> 12;
    if (r > SMAX) r = SMAX;
    return r;
  endfunction

  task automatic set_consts(input real a, input real b, input real g);
    k_alpha     = 16'($rtoi(a * 4096.0 + 0.5));
    k_alpha_inv = 16'($rtoi(4096.0 / a + 0.5));
    k_beta      = 16'($rtoi(b * 4096.0 + 0.5));
    k_beta_inv  = 16'($rtoi(4096.0 / b + 0.5));
    k_gamma     = 16'($rtoi(g * 4096.0 + 0.5));
    k_thresh    = 16'($rtoi(0.5 * (b + 1.0 / b) * 4096.0 + 0.5));
  endtask

  task automatic do_reset(input int istep);
    init_step = SW'(istep);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_y = 0; m_step = istep; m_dir = 1'b1; m_mag = 1'b1;   // R8
    check(code_valid == 1'b0, "R8", "code_valid after reset", int'(code_valid), 0);
  endtask

  task automatic send(input int x, input string tag);
    int e, ae, d1, thr, d2, st;
    bit dir, mag;
    e   = x - m_y;
    dir = (e >= 0);                                       // R2
    ae  = (e < 0) ? -e : e;
    d1  = q((dir == m_dir) ? int'(k_alpha) : int'(k_alpha_inv), m_step); // R3
    thr = q(int'(k_thresh), d1);
    mag = (ae >= thr);                                    // R4
    d2  = q(mag ? int'(k_beta) : int'(k_beta_inv), d1);   // R5
    st  = (!mag && !m_mag) ? q(int'(k_gamma), d2) : d2;
    if (st < int'(step_min)) st = int'(step_min);         // R6
    else if (st > int'(step_max)) st = int'(step_max);
    smp_in = DW'(x);
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
    check(code_valid == 1'b1, "R1", "code_valid after strobe", int'(code_valid), 1);
    check(code_sign == dir, tag, "code_sign", int'(code_sign), int'(dir));
    check(code_mag == mag, tag, "code_mag", int'(code_mag), int'(mag));
    m_y = dir ? m_y + st : m_y - st;                      // R7
    if (m_y > YMAX) m_y = YMAX;
    if (m_y < YMIN) m_y = YMIN;
    m_step = st; m_dir = dir; m_mag = mag;
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      smp_in = DW'(i * 37 - 300);   // changes that must be ignored
      @(negedge clk);
      check(code_valid == 1'b0, "R1", "code_valid without strobe", int'(code_valid), 0);
    end
  endtask

  initial begin
    step_min = 10'd2; step_max = 10'd400;
    set_consts(1.1, 1.9, 1.5);
    do_reset(8);
    // R8: first sample of zero uses the reset step and previous bits
    send(0, "R8 R2 R3");
    send(0, "R8 R4 R5");
    // R2 R3 R4 R5: square wave
    for (int c = 0; c < 4; c++) begin
      for (int i = 0; i < 25; i++) send(300, "R2 R3 R4 R5");
      for (int i = 0; i < 25; i++) send(-300, "R2 R3 R4 R5");
    end
    // R1: idle gap leaves state untouched
    idle(6);
    send(-300, "R1 R2 R4");
    // R2 R4: ramp sweep across the full input range, both directions
    for (int x = YMIN; x <= YMAX; x += 3) send(x, "R2 R4 R5");
    for (int x = YMAX; x >= YMIN; x -= 5) send(x, "R2 R4 R5");
    // R9: aggressive constants, wide steps reaching product saturation
    idle(2);
    set_consts(1.5, 2.5, 2.0);
    step_max = 10'd1023;
    for (int i = 0; i < 400; i++) send(int'($urandom_range(0, 1023)) - 512, "R9 R3 R5");
    for (int i = 0; i < 30; i++) send(YMAX, "R9 R7");
    // R7: prediction saturates at both rails
    for (int i = 0; i < 40; i++) send(YMIN, "R7");
    for (int i = 0; i < 40; i++) send(YMAX, "R7");
    // R6: tight clamp bounds
    idle(2);
    step_min = 10'd4; step_max = 10'd20;
    for (int c = 0; c < 6; c++) begin
      for (int i = 0; i < 12; i++) send(450, "R6");
      for (int i = 0; i < 12; i++) send(-450, "R6");
      for (int i = 0; i < 12; i++) send(3, "R6 R5");
    end
    // R8: reset mid-run with a new initial step
    idle(2);
    set_consts(1.1, 1.9, 1.5);
    step_min = 10'd1; step_max = 10'd600;
    do_reset(50);
    for (int i = 0; i < 200; i++) send((i * 29) % 700 - 350, "R8 R2 R4");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule